// File: doc/BRIEF.md
# Dual-Accumulator Fixed-Point MAC Datapath

This block is the arithmetic core of a fixed-point signal processor. It holds two 40-bit accumulators (A and B) and a 16-bit multiplicand register T. It shares one signed multiplier among all its product-based operations. Each enabled clock cycle it performs one operation chosen by a 4-bit opcode. The operations are plain multiply-accumulate and multiply-subtract, square-accumulate and square-subtract, and accumulation of an absolute difference or a squared distance between two vector elements. There are also two fused operations that update both accumulators in the same cycle: a Horner polynomial step and a symmetric-FIR tap step.

The surrounding sequencer supplies the operands every cycle: two samples `opnd_x`/`opnd_y` and a coefficient `opnd_c`. It reads results back as a high or low 16-bit word of either accumulator. It uses the two "less than or equal to zero" flags for conditional execution. A per-cycle mode input selects saturation to the 32-bit signed range or wraparound inside the eight guard bits.

Top module: `dual_acc_mac`

## Requirements
- R1: While reset is asserted, and after it is released, A, B and T read as zero and both flags are 1. The external reset is asynchronous and active low, and its release is resynchronised internally over two clock edges.
- R2: When `en` is 0, neither accumulator changes whatever the opcode. T is loaded from `t_in` on any edge with `t_wr` high, independently of `en`.
- R3: Opcode 0 leaves both accumulators unchanged. Opcode 1 clears the accumulator picked by `acc_sel` (0 = A, 1 = B). Opcode 2 loads it with `opnd_x` sign-extended and shifted left by 16.
- R4: Opcode 3 adds `opnd_x*opnd_y` (signed) to the selected accumulator. Opcode 4 subtracts that product from it.
- R5: Opcode 5 adds `opnd_x*opnd_x` to the selected accumulator. Opcode 6 subtracts that square from it.
- R6: Opcode 7 adds |`opnd_x`-`opnd_y`| to the selected accumulator. Opcode 8 adds (`opnd_x`-`opnd_y`)^2. The difference is formed to 17 bits, so it cannot overflow.
- R7: Opcode 9 (polynomial step) sets A = B + T*A[31:16]. In the same cycle it loads B with `opnd_x` sign-extended and shifted left by 16.
- R8: Opcode 10 (symmetric-FIR step) sets B = B + `opnd_c`*A[31:16]. In the same cycle it reloads A with (`opnd_x`+`opnd_y`) shifted left by 16.
- R9: When `sat_en` is 1, every arithmetic result (opcodes 3 to 10, except the B load of opcode 9) is clamped to the range 0xFF80000000 to 0x007FFFFFFF.
- R10: When `sat_en` is 0, arithmetic results wrap modulo 2^40.
- R11: `rd_hi` returns bits 31:16 and `rd_lo` returns bits 15:0 of A when `rd_sel` is 0, or of B when it is 1.
- R12: `le_zero_a` and `le_zero_b` are 1 exactly when the corresponding accumulator, read as a signed value, is less than or equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Accumulator update enable |
| op | input | 4 | Operation code |
| acc_sel | input | 1 | Target accumulator for single-accumulator operations (0 = A, 1 = B) |
| sat_en | input | 1 | 1 = saturate to 32-bit signed range, 0 = wrap |
| opnd_x | input | 16 | First data operand |
| opnd_y | input | 16 | Second data operand |
| opnd_c | input | 16 | Coefficient for the FIR step |
| t_wr | input | 1 | Load enable for T |
| t_in | input | 16 | New value for T |
| rd_sel | input | 1 | Readback accumulator select (0 = A, 1 = B) |
| rd_hi | output | 16 | Bits 31:16 of the selected accumulator |
| rd_lo | output | 16 | Bits 15:0 of the selected accumulator |
| acc_a_o | output | 40 | Full contents of A |
| acc_b_o | output | 40 | Full contents of B |
| le_zero_a | output | 1 | A <= 0 |
| le_zero_b | output | 1 | B <= 0 |

## Verification
Every accumulator update is registered once. The result of an operation presented before a rising edge appears on `acc_a_o`/`acc_b_o` just after that edge. The readback words and the flags follow combinationally, so they carry that same new value in the same cycle. A T load is used by a polynomial step only from the edge after it is written. The bench drives all inputs on the falling edge and advances its model at the rising edge, using the old T. It compares all outputs at the following falling edge, one edge after the stimulus.

// File: rtl/dacc_pkg.sv
package dacc_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_CLR  = 4'd1,
    OP_LDH  = 4'd2,
    OP_MAC  = 4'd3,
    OP_MAS  = 4'd4,
    OP_SQA  = 4'd5,
    OP_SQS  = 4'd6,
    OP_ABD  = 4'd7,
    OP_SQD  = 4'd8,
    OP_POLY = 4'd9,
    OP_FIRS = 4'd10
  } dacc_op_e;

endpackage

// File: rtl/dacc_rst_sync.sv
module dacc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/dacc_opsel.sv
module dacc_opsel
  import dacc_pkg::*;
#(
  parameter int DW = 16,
  localparam int MW = DW + 1
) (
  input  dacc_op_e             op_i,
  input  logic [DW-1:0]        x_i,
  input  logic [DW-1:0]        y_i,
  input  logic [DW-1:0]        c_i,
  input  logic [DW-1:0]        t_i,
  input  logic [DW-1:0]        a_hi_i,
  output logic signed [MW-1:0] diff_o,
  output logic signed [MW-1:0] mul_l_o,
  output logic signed [MW-1:0] mul_r_o
);
  logic signed [MW-1:0] x_e, y_e, c_e, t_e, ah_e;

  assign x_e  = {x_i[DW-1], x_i};
  assign y_e  = {y_i[DW-1], y_i};
  assign c_e  = {c_i[DW-1], c_i};
  assign t_e  = {t_i[DW-1], t_i};
  assign ah_e = {a_hi_i[DW-1], a_hi_i};
  assign diff_o = x_e - y_e;

  always_comb begin
    unique case (op_i)
      OP_SQA, OP_SQS: begin mul_l_o = x_e;    mul_r_o = x_e;    end
      OP_SQD:         begin mul_l_o = diff_o; mul_r_o = diff_o; end
      OP_POLY:        begin mul_l_o = t_e;    mul_r_o = ah_e;   end
      OP_FIRS:        begin mul_l_o = c_e;    mul_r_o = ah_e;   end
      default:        begin mul_l_o = x_e;    mul_r_o = y_e;    end
    endcase
  end
endmodule

// File: rtl/dacc_mul.sv
module dacc_mul #(
  parameter int MW = 17,
  localparam int PW = 2 * MW
) (
  input  logic signed [MW-1:0] a_i,
  input  logic signed [MW-1:0] b_i,
  output logic signed [PW-1:0] p_o
);
  logic signed [PW-1:0] a_w, b_w;

  assign a_w = {{MW{a_i[MW-1]}}, a_i};
  assign b_w = {{MW{b_i[MW-1]}}, b_i};
  assign p_o = a_w * b_w;
endmodule

// File: rtl/dacc_lim.sv
module dacc_lim #(
  parameter int AW   = 40,
  parameter int SW   = 32,
  parameter int SUMW = 42
) (
  input  logic signed [SUMW-1:0] sum_i,
  input  logic                   sat_en,
  output logic [AW-1:0]          res_o
);
  localparam logic signed [SUMW-1:0] HI = {{(SUMW-SW+1){1'b0}}, {(SW-1){1'b1}}};
  localparam logic signed [SUMW-1:0] LO = {{(SUMW-SW+1){1'b1}}, {(SW-1){1'b0}}};

  always_comb begin
    if (sat_en && (sum_i > HI))      res_o = HI[AW-1:0];
    else if (sat_en && (sum_i < LO)) res_o = LO[AW-1:0];
    else                             res_o = sum_i[AW-1:0];
  end
endmodule

// File: rtl/dual_acc_mac.sv
module dual_acc_mac
  import dacc_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 40,
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [3:0]    op,
  input  logic          acc_sel,
  input  logic          sat_en,
  input  logic [DW-1:0] opnd_x,
  input  logic [DW-1:0] opnd_y,
  input  logic [DW-1:0] opnd_c,
  input  logic          t_wr,
  input  logic [DW-1:0] t_in,
  input  logic          rd_sel,
  output logic [DW-1:0] rd_hi,
  output logic [DW-1:0] rd_lo,
  output logic [AW-1:0] acc_a_o,
  output logic [AW-1:0] acc_b_o,
  output logic          le_zero_a,
  output logic          le_zero_b
);
  localparam int MW   = DW + 1;
  localparam int PW   = 2 * MW;
  localparam int SUMW = AW + 2;
  localparam int NLANE = 2;

  dacc_op_e op_e;
  logic rst_sync_n;

  logic [AW-1:0] acc_a_q, acc_b_q, nxt_a, nxt_b;
  logic [DW-1:0] t_q;

  logic signed [MW-1:0]   diff, absd, mul_l, mul_r, pair;
  logic signed [PW-1:0]   prod;
  logic signed [SUMW-1:0] a_ext, b_ext, prod_ext, absd_ext, pair_ext, addend;
  logic signed [SUMW-1:0] lane_sum [NLANE];
  logic [AW-1:0]          lane_res [NLANE];
  logic [AW-1:0]          ldh_val;

  assign op_e = dacc_op_e'(op);

  dacc_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  dacc_opsel #(.DW(DW)) u_opsel (
    .op_i    (op_e),
    .x_i     (opnd_x),
    .y_i     (opnd_y),
    .c_i     (opnd_c),
    .t_i     (t_q),
    .a_hi_i  (acc_a_q[2*DW-1:DW]),
    .diff_o  (diff),
    .mul_l_o (mul_l),
    .mul_r_o (mul_r)
  );

  dacc_mul #(.MW(MW)) u_mul (
    .a_i (mul_l),
    .b_i (mul_r),
    .p_o (prod)
  );

  // operand conditioning
  assign pair     = {opnd_x[DW-1], opnd_x} + {opnd_y[DW-1], opnd_y};
  assign absd     = diff[MW-1] ? -diff : diff;
  assign a_ext    = {{(SUMW-AW){acc_a_q[AW-1]}}, acc_a_q};
  assign b_ext    = {{(SUMW-AW){acc_b_q[AW-1]}}, acc_b_q};
  assign prod_ext = {{(SUMW-PW){prod[PW-1]}}, prod};
  assign absd_ext = {{(SUMW-MW){absd[MW-1]}}, absd};
  assign pair_ext = {{(SUMW-MW-DW){pair[MW-1]}}, pair, {DW{1'b0}}};
  assign ldh_val  = {{(AW-2*DW){opnd_x[DW-1]}}, opnd_x, {DW{1'b0}}};

  always_comb begin
    unique case (op_e)
      OP_MAC, OP_SQA, OP_SQD: addend = prod_ext;
      OP_MAS, OP_SQS:         addend = -prod_ext;
      OP_ABD:                 addend = absd_ext;
      default:                addend = '0;
    endcase
  end

  // lane 0 feeds A, lane 1 feeds B
  always_comb begin
    unique case (op_e)
      OP_POLY: lane_sum[0] = b_ext + prod_ext;
      OP_FIRS: lane_sum[0] = pair_ext;
      default: lane_sum[0] = a_ext + addend;
    endcase
    if (op_e == OP_FIRS) lane_sum[1] = b_ext + prod_ext;
    else                 lane_sum[1] = b_ext + addend;
  end

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    dacc_lim #(.AW(AW), .SW(SW), .SUMW(SUMW)) u_lim (
      .sum_i  (lane_sum[g]),
      .sat_en (sat_en),
      .res_o  (lane_res[g])
    );
  end

  // next-state
  always_comb begin
    nxt_a = acc_a_q;
    nxt_b = acc_b_q;
    unique case (op_e)
      OP_CLR: begin
        if (acc_sel) nxt_b = '0;
        else         nxt_a = '0;
      end
      OP_LDH: begin
        if (acc_sel) nxt_b = ldh_val;
        else         nxt_a = ldh_val;
      end
      OP_MAC, OP_MAS, OP_SQA, OP_SQS, OP_ABD, OP_SQD: begin
        if (acc_sel) nxt_b = lane_res[1];
        else         nxt_a = lane_res[0];
      end
      OP_POLY: begin
        nxt_a = lane_res[0];
        nxt_b = ldh_val;
      end
      OP_FIRS: begin
        nxt_a = lane_res[0];
        nxt_b = lane_res[1];
      end
      default: ;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      acc_a_q <= '0;
      acc_b_q <= '0;
    end else if (en) begin
      acc_a_q <= nxt_a;
      acc_b_q <= nxt_b;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  t_q <= '0;
    else if (t_wr)    t_q <= t_in;
  end

  // outputs
  assign acc_a_o   = acc_a_q;
  assign acc_b_o   = acc_b_q;
  assign rd_hi     = rd_sel ? acc_b_q[2*DW-1:DW] : acc_a_q[2*DW-1:DW];
  assign rd_lo     = rd_sel ? acc_b_q[DW-1:0]    : acc_a_q[DW-1:0];
  assign le_zero_a = acc_a_q[AW-1] | ~(|acc_a_q);
  assign le_zero_b = acc_b_q[AW-1] | ~(|acc_b_q);
endmodule

// File: rtl/dacc_chk.sv
module dacc_chk
  import dacc_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 40,
  parameter int SW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic [3:0]    op,
  input logic          acc_sel,
  input logic          sat_en,
  input logic [DW-1:0] opnd_x,
  input logic [AW-1:0] acc_a_o,
  input logic [AW-1:0] acc_b_o,
  input logic          le_zero_a,
  input logic          le_zero_b
);
  logic a_in_rng, b_in_rng;
  assign a_in_rng = (&acc_a_o[AW-1:SW-1]) | ~(|acc_a_o[AW-1:SW-1]);
  assign b_in_rng = (&acc_b_o[AW-1:SW-1]) | ~(|acc_b_o[AW-1:SW-1]);

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(acc_a_o) && $stable(acc_b_o)));

  // R3
  load_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == OP_LDH && !acc_sel) |=>
      (acc_a_o == {{(AW-2*DW){$past(opnd_x[DW-1])}}, $past(opnd_x), {DW{1'b0}}}));

  // R12
  clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == OP_CLR && acc_sel) |=> (le_zero_b && acc_b_o == '0));

  // R7
  poly_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == OP_POLY) |=>
      (acc_b_o == {{(AW-2*DW){$past(opnd_x[DW-1])}}, $past(opnd_x), {DW{1'b0}}}));

  // R9
  sat_range_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sat_en && !acc_sel && op >= OP_MAC && op <= OP_SQD) |=> a_in_rng);

  // R9
  sat_range_fir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sat_en && op == OP_FIRS) |=> (a_in_rng && b_in_rng));
endmodule

bind dual_acc_mac dacc_chk #(.DW(DW), .AW(AW), .SW(SW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .en        (en),
  .op        (op),
  .acc_sel   (acc_sel),
  .sat_en    (sat_en),
  .opnd_x    (opnd_x),
  .acc_a_o   (acc_a_o),
  .acc_b_o   (acc_b_o),
  .le_zero_a (le_zero_a),
  .le_zero_b (le_zero_b)
);

// File: tb/dual_acc_mac_bench.sv
`timescale 1ns/1ps
module dual_acc_mac_bench;
  logic        clk = 1'b0;
  logic        rst_n, en, acc_sel, sat_en, t_wr, rd_sel;
  logic [3:0]  op;
  logic [15:0] opnd_x, opnd_y, opnd_c, t_in, rd_hi, rd_lo;
  logic [39:0] acc_a_o, acc_b_o;
  logic        le_zero_a, le_zero_b;

  int n_chk = 0;
  int n_bad = 0;
  longint ma, mb;
  logic [15:0] mt;

  always #2.5 clk = ~clk;

  dual_acc_mac u_dual_acc_mac (.*);

  task automatic chk(input string rq, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] o, input bit e);
    if (!e) return "R2";
    case (o)
      0, 1, 2: return "R3";
      3, 4:    return "R4";
      5, 6:    return "R5";
      7, 8:    return "R6";
      9:       return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic longint lim(input longint s, input bit sat);
    longint w;
    if (sat) begin
      if (s > 64'sh7FFFFFFF)  return 64'sh7FFFFFFF;
      if (s < -64'sh80000000) return -64'sh80000000;
      return s;
    end
    w = {{24{s[39]}}, s[39:0]};
    return w;
  endfunction

  function automatic longint hi16(input longint v);
    longint r;
    r = longint'($signed(v[31:16]));
    return r;
  endfunction

  task automatic model_step(input logic [3:0] o, input bit s, input logic [15:0] x, y, c,
                            input bit sat, input bit e, input bit tw, input logic [15:0] tv);
    longint xs, ys, cs, ts, d, ld, na, nb;
    xs = longint'($signed(x)); ys = longint'($signed(y));
    cs = longint'($signed(c)); ts = longint'($signed(mt));
    d  = xs - ys; ld = xs * 65536;
    na = ma; nb = mb;
    if (e) begin
      case (o)
        1: if (s) nb = 0; else na = 0;
        2: if (s) nb = ld; else na = ld;
        3: if (s) nb = lim(mb + xs*ys, sat); else na = lim(ma + xs*ys, sat);
        4: if (s) nb = lim(mb - xs*ys, sat); else na = lim(ma - xs*ys, sat);
        5: if (s) nb = lim(mb + xs*xs, sat); else na = lim(ma + xs*xs, sat);
        6: if (s) nb = lim(mb - xs*xs, sat); else na = lim(ma - xs*xs, sat);
        7: if (s) nb = lim(mb + (d < 0 ? -d : d), sat); else na = lim(ma + (d < 0 ? -d : d), sat);
        8: if (s) nb = lim(mb + d*d, sat); else na = lim(ma + d*d, sat);
        9: begin na = lim(mb + ts*hi16(ma), sat); nb = ld; end
        10: begin na = lim((xs + ys) * 65536, sat); nb = lim(mb + cs*hi16(ma), sat); end
        default: ;
      endcase
    end
    ma = na; mb = nb;
    if (tw) mt = tv;
  endtask

  task automatic apply(input logic [3:0] o, input bit s, input logic [15:0] x, y, c,
                       input bit sat, input bit e, input bit tw, input logic [15:0] tv, input bit rs);
    longint sel;
    string t;
    op = o; acc_sel = s; opnd_x = x; opnd_y = y; opnd_c = c;
    sat_en = sat; en = e; t_wr = tw; t_in = tv; rd_sel = rs;
    @(posedge clk);
    model_step(o, s, x, y, c, sat, e, tw, tv);
    @(negedge clk);
    t = tag_of(o, e);
    if (e && sat && o >= 3) t = {t, "/R9"};
    if (e && !sat && o >= 3) t = {t, "/R10"};
    chk({t, " acc A"}, acc_a_o, ma[39:0]);
    chk({t, " acc B"}, acc_b_o, mb[39:0]);
    sel = rs ? mb : ma;
    chk("R11 rd_hi", {24'b0, rd_hi}, {24'b0, sel[31:16]});
    chk("R11 rd_lo", {24'b0, rd_lo}, {24'b0, sel[15:0]});
    chk("R12 le_zero_a", {39'b0, le_zero_a}, {39'b0, ma <= 0});
    chk("R12 le_zero_b", {39'b0, le_zero_b}, {39'b0, mb <= 0});
  endtask

  function automatic logic [15:0] rnd16();
    int k;
    k = $urandom % 8;
    if (k == 0) return 16'h7FFF;
    if (k == 1) return 16'h8000;
    if (k == 2) return 16'h0000;
    return 16'($urandom);
  endfunction

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    ma = 0; mb = 0; mt = 16'h0;
    rst_n = 1'b0; en = 1'b0; op = 4'd0; acc_sel = 1'b0; sat_en = 1'b0;
    opnd_x = '0; opnd_y = '0; opnd_c = '0; t_wr = 1'b0; t_in = '0; rd_sel = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state while asserted
    chk("R1 A in reset", acc_a_o, 40'h0);
    chk("R1 flag A in reset", {39'b0, le_zero_a}, 40'h1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 A after release", acc_a_o, 40'h0);
    chk("R1 B after release", acc_b_o, 40'h0);
    chk("R1 flag B", {39'b0, le_zero_b}, 40'h1);
    // R1: T is zero: poly step with A loaded gives A = B + 0
    apply(4'd2, 0, 16'h0123, 0, 0, 0, 1, 0, 0, 0);
    apply(4'd9, 0, 16'h0005, 0, 0, 0, 1, 0, 0, 0);
    chk("R1 T zero via poly", acc_a_o, 40'h0);

    // R3 / R9: saturating positive corner
    apply(4'd2, 0, 16'h7FFF, 0, 0, 1, 1, 0, 0, 0);
    chk("R3 load high", acc_a_o, 40'h007FFF0000);
    apply(4'd3, 0, 16'h7FFF, 16'h7FFF, 0, 1, 1, 0, 0, 0);
    chk("R9 positive clamp", acc_a_o, 40'h007FFFFFFF);
    // R10: same in wrap mode
    apply(4'd2, 0, 16'h7FFF, 0, 0, 0, 1, 0, 0, 1);
    apply(4'd3, 0, 16'h7FFF, 16'h7FFF, 0, 0, 1, 0, 0, 0);
    chk("R10 wrap guard bits", acc_a_o, 40'h00BFFE0001);
    // R9: negative corner on B
    apply(4'd2, 1, 16'h8000, 0, 0, 1, 1, 0, 0, 1);
    chk("R3 load high negative", acc_b_o, 40'hFF80000000);
    apply(4'd4, 1, 16'h7FFF, 16'h7FFF, 0, 1, 1, 0, 0, 1);
    chk("R9 negative clamp", acc_b_o, 40'hFF80000000);
    // R2: disabled MAC leaves both accumulators
    apply(4'd3, 1, 16'h1234, 16'h0100, 0, 0, 0, 0, 0, 1);
    chk("R2 hold B", acc_b_o, 40'hFF80000000);
    // R6: extreme difference
    apply(4'd1, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    apply(4'd7, 0, 16'h8000, 16'h7FFF, 0, 0, 1, 0, 0, 0);
    chk("R6 abs diff", acc_a_o, 40'h000000FFFF);
    apply(4'd1, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    apply(4'd8, 0, 16'h8000, 16'h7FFF, 0, 0, 1, 0, 0, 0);
    chk("R6 sq dist wrap", acc_a_o, 40'h00FFFE0001);
    // R5: square subtract
    apply(4'd1, 1, 0, 0, 0, 0, 1, 0, 0, 0);
    apply(4'd6, 1, 16'h0003, 0, 0, 0, 1, 0, 0, 1);
    chk("R5 square subtract", acc_b_o, 40'hFFFFFFFFF7);
    // R7: Horner steps with T=2, c3=1, c2=3
    apply(4'd2, 1, 16'h0001, 0, 0, 0, 1, 1, 16'h0002, 0);
    apply(4'd1, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    apply(4'd9, 0, 16'h0003, 0, 0, 0, 1, 0, 0, 0);
    chk("R7 poly step 1 A", acc_a_o, 40'h0000010000);
    apply(4'd9, 0, 16'h0000, 0, 0, 0, 1, 0, 0, 0);
    chk("R7 poly step 2 A", acc_a_o, 40'h0000030002);
    // R8: FIR step, A hi = 3 from above
    apply(4'd1, 1, 0, 0, 0, 0, 1, 0, 0, 1);
    apply(4'd10, 0, 16'h0004, 16'h0005, 16'h0007, 0, 1, 0, 0, 0);
    chk("R8 fir B", acc_b_o, 40'h0000000015);
    chk("R8 fir A reload", acc_a_o, 40'h0000090000);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      apply(4'($urandom % 11), 1'($urandom), rnd16(), rnd16(), rnd16(),
            1'($urandom), ($urandom % 10) != 0, ($urandom % 3) == 0, rnd16(), 1'($urandom));
    end

    summary();
    $finish;
  end
endmodule